// File: doc/BRIEF.md
# Synchronous serial port with selectable clock source

This block moves one word at a time over a three-wire synchronous serial link: one clock line, one data line out and one data line in. As a master it makes the serial clock by dividing the system clock. As a slave it follows a clock driven from outside, which it passes through a synchroniser. An 8-bit mode register enables the port and sets these options:

- full-duplex or receive-only operation
- 8-bit or 16-bit words
- MSB-first or LSB-first order
- an optional half-period delay of the completion interrupt
- single or repeat operation

A read-only busy flag shows that a transfer is running.

Software starts a full-duplex word by writing the transmit strobe. It starts a receive-only word by pulsing the receive-buffer read strobe. A one-cycle interrupt pulse marks the end of every word. In repeat mode, the next word starts on its own if software supplied a new start request while the current word was shifting.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the mode register reads 0x00, the serial clock output is high, the data output is low, the clock output enable is low and the interrupt is low.
- R2: The mode register reads as follows: bit 7 enable, bit 6 duplex, bit 5 wide (16-bit), bit 4 LSB-first, bit 3 late interrupt, bit 2 repeat, bit 1 always 0, bit 0 busy. Writes to bits 1 and 0 have no effect, so writing 0xFF while idle reads back 0xFC.
- R3: When enabled with duplex=1, a transmit write while idle starts a transfer. The busy flag is 1 on the cycle after the write and stays 1 until completion. The bits sampled from the data input are then returned on the receive buffer.
- R4: With duplex=0 the data output stays low at all times. A receive-buffer read strobe starts a transfer, and a transmit write starts nothing.
- R5: Each transfer is 8 bits when wide=0 and 16 bits when wide=1. An 8-bit result is right-justified in the receive buffer with the upper byte zero.
- R6: With LSB-first=0 the most significant bit goes out and comes in first. With LSB-first=1 the least significant bit goes first. The setting applies to both directions.
- R7: Clock select values 0 to 6 pick master mode with a half period of 2^sel system clocks. The serial clock idles high. Data changes after a falling edge and is sampled on the rising edge. The interrupt comes 2·N·2^sel cycles after the start edge, where N is the word length.
- R8: Clock select 7 picks slave mode. In slave mode the clock output enable is 0 and the port shifts on edges of the external clock. The interrupt pulses 3 system cycles after the external clock's last rising edge.
- R9: The interrupt is a single-cycle pulse. With the late bit set in master mode it comes 2^sel cycles later than normal. In slave mode the late bit has no effect.
- R10: While busy is 1, writes change only the enable bit. Bits 6 to 2 hold their values.
- R11: Writing enable=0 stops any transfer, clears busy on the next cycle, returns the clock output high and suppresses that transfer's interrupt. While the port is disabled, start requests are ignored.
- R12: With repeat=1, a start request taken during a transfer is held. When the current word completes, the interrupt pulses, busy stays 1 and the held word is shifted next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Mode register write strobe |
| ctl_wdata | input | 8 | Mode register write data |
| ctl_rdata | output | 8 | Mode register read value, including busy |
| clk_sel | input | SEL_W | Clock select: 0..6 master divide, 7 slave |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_W | Transmit word |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_rdata | output | DATA_W | Last received word |
| sck_i | input | 1 | External serial clock (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| irq_o | output | 1 | Transfer-complete pulse |

## Verification
The main path is run through a vector table that crosses word length, bit order, duplex versus receive-only, interrupt delay and divider settings. It uses unequal transmit and receive patterns, so a swapped bit order, a truncated word or a wrong divide ratio each gives a different captured value or cycle count. A slave run drives the external clock by hand, which separates synchronised edge detection from the internal divider and shows that the delay bit is inert there. Directed runs cover the register lock, disabling mid-transfer, start requests that must be ignored, and back-to-back words in repeat mode.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef struct packed {
        logic en;
        logic duplex;
        logic wide;
        logic lsb;
        logic late;
        logic rpt;
    } ssp_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATE  = 2'd2
    } ssp_state_e;

endpackage

// File: rtl/ssp_mode_reg.sv
module ssp_mode_reg
    import ssp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       busy_i,
    output ssp_mode_t  mode_o,
    output logic [7:0] rdata_o
);

    ssp_mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_i) begin
            mode_d.en = wdata_i[7];
            // configuration fields are frozen while a word is in flight
            if (!busy_i) begin
                mode_d.duplex = wdata_i[6];
                mode_d.wide   = wdata_i[5];
                mode_d.lsb    = wdata_i[4];
                mode_d.late   = wdata_i[3];
                mode_d.rpt    = wdata_i[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode_o  = mode_q;
    assign rdata_o = {mode_q.en, mode_q.duplex, mode_q.wide, mode_q.lsb,
                      mode_q.late, mode_q.rpt, 1'b0, busy_i};

endmodule

// File: rtl/ssp_edge_gen.sv
module ssp_edge_gen #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             run_i,
    input  logic             sck_i,
    output logic             tick_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam int CNT_W = (MAX_SEL < 1) ? 1 : MAX_SEL;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             s1;
        logic             s2;
        logic             s3;
    } eg_t;

    eg_t eg_d, eg_q;
    logic [SEL_W-1:0] sh;
    logic [CNT_W-1:0] lim;

    always_comb begin
        // half period of 2^sel clocks: count limit is 2^sel - 1
        sh     = SEL_W'(CNT_W) - sel_i;
        lim    = {CNT_W{1'b1}} >> sh;
        tick_o = run_i && (eg_q.cnt == lim);

        eg_d    = eg_q;
        eg_d.s1 = sck_i;
        eg_d.s2 = eg_q.s1;
        eg_d.s3 = eg_q.s2;
        if (!run_i || tick_o) eg_d.cnt = '0;
        else                  eg_d.cnt = eg_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eg_q <= '{cnt: '0, s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        eg_q <= eg_d;
    end

    assign rise_o = eg_q.s2 & ~eg_q.s3;
    assign fall_o = ~eg_q.s2 & eg_q.s3;

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ssp_mode_t         mode_i,
    input  logic              master_i,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic              s_rise_i,
    input  logic              s_fall_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    input  logic              rx_rd_i,
    input  logic              sd_i,
    output logic              busy_o,
    output logic              sck_o,
    output logic              sd_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] rx_data_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int BC_W   = $clog2(DATA_W);

    typedef struct packed {
        ssp_state_e        state;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] txb;
        logic [DATA_W-1:0] rxb;
        logic [BC_W-1:0]   bcnt;
        logic              pend;
        logic              sck;
        logic              sd;
        logic              irq;
    } eng_t;

    eng_t e_d, e_q;

    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic wide);
        return wide ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic wide, input logic lsb);
        return lsb ? v[0] : (wide ? v[DATA_W-1] : v[HALF_W-1]);
    endfunction

    function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v, input logic smp,
                                                   input logic wide, input logic lsb);
        logic [DATA_W-1:0] r;
        if (lsb) begin
            r = v >> 1;
            if (wide) r[DATA_W-1] = smp;
            else      r[HALF_W-1] = smp;
        end else begin
            r = {v[DATA_W-2:0], smp};
        end
        return r;
    endfunction

    logic              fall_ev, rise_ev, req, finish;
    logic [DATA_W-1:0] req_data;
    logic [BC_W-1:0]   last;

    always_comb begin
        fall_ev  = master_i ? (tick_i && e_q.sck)  : s_fall_i;
        rise_ev  = master_i ? (tick_i && !e_q.sck) : s_rise_i;
        req      = mode_i.en && (mode_i.duplex ? tx_wr_i : rx_rd_i);
        req_data = mode_i.duplex ? tx_wdata_i : '0;
        last     = mode_i.wide ? BC_W'(DATA_W-1) : BC_W'(HALF_W-1);
        finish   = 1'b0;

        e_d     = e_q;
        e_d.irq = 1'b0;

        if (clr_i || !mode_i.en) begin
            e_d.state = ST_IDLE;
            e_d.sck   = 1'b1;
            e_d.sd    = 1'b0;
            e_d.pend  = 1'b0;
            e_d.bcnt  = '0;
        end else begin
            case (e_q.state)
                ST_IDLE: begin
                    if (req) begin
                        e_d.state = ST_SHIFT;
                        e_d.sr    = fit(req_data, mode_i.wide);
                        e_d.sd    = head_bit(e_d.sr, mode_i.wide, mode_i.lsb);
                        e_d.bcnt  = '0;
                        e_d.sck   = 1'b1;
                    end
                end
                ST_SHIFT, ST_LATE: begin
                    if (req && mode_i.rpt) begin
                        e_d.txb  = req_data;
                        e_d.pend = 1'b1;
                    end
                    if (e_q.state == ST_SHIFT) begin
                        if (fall_ev) begin
                            e_d.sck = 1'b0;
                            e_d.sd  = head_bit(e_q.sr, mode_i.wide, mode_i.lsb);
                        end
                        if (rise_ev) begin
                            e_d.sck  = 1'b1;
                            e_d.sr   = shift_in(e_q.sr, sd_i, mode_i.wide, mode_i.lsb);
                            e_d.bcnt = e_q.bcnt + 1'b1;
                            if (e_q.bcnt == last) begin
                                e_d.rxb = fit(e_d.sr, mode_i.wide);
                                if (mode_i.late && master_i) e_d.state = ST_LATE;
                                else                         finish    = 1'b1;
                            end
                        end
                    end else if (tick_i) begin
                        finish = 1'b1;
                    end
                    if (finish) begin
                        e_d.irq = 1'b1;
                        if (mode_i.rpt && e_d.pend) begin
                            e_d.state = ST_SHIFT;
                            e_d.sr    = fit(e_d.txb, mode_i.wide);
                            e_d.sd    = head_bit(e_d.sr, mode_i.wide, mode_i.lsb);
                            e_d.bcnt  = '0;
                            e_d.pend  = 1'b0;
                        end else begin
                            e_d.state = ST_IDLE;
                        end
                    end
                end
                default: e_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ST_IDLE;
            e_q.sck   <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy_o    = (e_q.state != ST_IDLE);
    assign sck_o     = e_q.sck;
    assign sd_o      = mode_i.duplex & e_q.sd;
    assign irq_o     = e_q.irq;
    assign rx_data_o = e_q.rxb;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              irq_o
);

    ssp_mode_t mode;
    logic      busy, master, clr, tick, s_rise, s_fall, eng_sck;

    assign master = (clk_sel != {SEL_W{1'b1}});
    assign clr    = ctl_wr && !ctl_wdata[7];

    ssp_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .busy_i  (busy),
        .mode_o  (mode),
        .rdata_o (ctl_rdata)
    );

    ssp_edge_gen #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (clk_sel),
        .run_i  (busy),
        .sck_i  (sck_i),
        .tick_o (tick),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    ssp_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .master_i   (master),
        .clr_i      (clr),
        .tick_i     (tick),
        .s_rise_i   (s_rise),
        .s_fall_i   (s_fall),
        .tx_wr_i    (tx_wr),
        .tx_wdata_i (tx_wdata),
        .rx_rd_i    (rx_rd),
        .sd_i       (sd_i),
        .busy_o     (busy),
        .sck_o      (eng_sck),
        .sd_o       (sd_o),
        .irq_o      (irq_o),
        .rx_data_o  (rx_rdata)
    );

    assign sck_o  = master ? eng_sck : 1'b1;
    assign sck_oe = mode.en && master;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dis_req,
    input logic             busy,
    input logic             duplex,
    input logic [4:0]       cfg,
    input logic [SEL_W-1:0] clk_sel,
    input logic             sck_o,
    input logic             sck_oe,
    input logic             sd_o,
    input logic             irq_o
);

    // R9: completion pulse lasts one cycle
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4: receive-only keeps the data line low
    p_rxonly_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !duplex |-> !sd_o);

    // R10: configuration frozen while busy
    p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));

    // R7: clock idles high
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);

    // R11: disabling clears busy and suppresses the interrupt
    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (!busy && !irq_o));

    // R8: slave mode never drives the clock
    p_slave_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == {SEL_W{1'b1}}) |-> !sck_oe);

endmodule

bind sync_serial_port ssp_checker #(.SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dis_req (ctl_wr && !ctl_wdata[7]),
    .busy    (ctl_rdata[0]),
    .duplex  (ctl_rdata[6]),
    .cfg     (ctl_rdata[6:2]),
    .clk_sel (clk_sel),
    .sck_o   (sck_o),
    .sck_oe  (sck_oe),
    .sd_o    (sd_o),
    .irq_o   (irq_o)
);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic [2:0]  clk_sel = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic        sck_i = 1'b1;
    logic        sck_o, sck_oe, sd_o, irq_o;
    logic        sd_drv = 1'b0;

    always #10 clk = ~clk;

    sync_serial_port uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .clk_sel(clk_sel), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .sd_i(sd_drv), .sd_o(sd_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // external device model for master-mode runs
    logic        dev_on = 1'b0;
    logic        prev_sck = 1'b1;
    int          dev_k = 0, cap_k = 0, sd_hi = 0, irq_cnt = 0;
    logic [15:0] cap = '0, cur_pat = '0;
    logic        cur_wide = 1'b0, cur_lsb = 1'b0;

    function automatic int bpos(input int k, input logic w, input logic l);
        int nb = w ? 16 : 8;
        if (k >= nb) return 0;
        return l ? k : nb - 1 - k;
    endfunction

    always @(negedge clk) begin
        if (dev_on) begin
            if (prev_sck && !sck_o) begin
                sd_drv = cur_pat[bpos(dev_k, cur_wide, cur_lsb)];
                dev_k++;
            end
            if (!prev_sck && sck_o) begin
                cap[bpos(cap_k, cur_wide, cur_lsb)] = sd_o;
                cap_k++;
            end
        end
        prev_sck = sck_o;
        if (!ctl_rdata[6] && sd_o) sd_hi++;
        if (irq_o) irq_cnt++;
    end

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; cyc(); ctl_wr = 1'b0;
    endtask

    task automatic start_tx(input logic [15:0] v);
        tx_wr = 1'b1; tx_wdata = v; cyc(); tx_wr = 1'b0;
    endtask

    task automatic start_rx();
        rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 5000) begin cyc(); n++; end
    endtask

    typedef struct packed {
        logic [15:0] tx;
        logic [15:0] pat;
        logic [2:0]  sel;
        logic        duplex;
        logic        wide;
        logic        lsb;
        logic        late;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'hA5C3, 16'h3C5A, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'h1234, 16'hBEEF, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{16'h00B1, 16'h0096, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{16'h8001, 16'h7FFE, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1},
        '{16'hFFFF, 16'h00C7, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h0000, 16'h5A3C, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1},
        '{16'h6E19, 16'h0F0F, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R3 actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, base;
        logic [15:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mode reg", ctl_rdata, 8'h00);
        chk("R1 sck_o", sck_o, 1'b1);
        chk("R1 sd_o", sd_o, 1'b0);
        chk("R1 sck_oe", sck_oe, 1'b0);
        chk("R1 irq", irq_o, 1'b0);

        // R2 register layout, reserved and busy bits not writable
        wr_ctl(8'hFF);
        chk("R2 readback 0xFF", ctl_rdata, 8'hFC);
        wr_ctl(8'h00);
        chk("R2 readback 0x00", ctl_rdata, 8'h00);

        // table-driven main function
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            int nb, h, exp_cyc;
            logic [15:0] msk;
            v = VECS[i];
            nb = v.wide ? 16 : 8;
            h = 1 << v.sel;
            exp_cyc = 2 * nb * h + (v.late ? h : 0);
            msk = v.wide ? 16'hFFFF : 16'h00FF;
            clk_sel = v.sel;
            wr_ctl({1'b1, v.duplex, v.wide, v.lsb, v.late, 3'b000});
            cur_pat = v.pat; cur_wide = v.wide; cur_lsb = v.lsb;
            dev_k = 0; cap_k = 0; cap = '0; sd_hi = 0; sd_drv = 1'b0; dev_on = 1'b1;
            if (v.duplex) start_tx(v.tx);
            else          start_rx();
            chk($sformatf("R3 busy after start v%0d", i), ctl_rdata[0], 1'b1);
            wait_irq(n);
            chk($sformatf("R7/R9 cycles to irq v%0d", i), n, exp_cyc);
            cyc();
            chk($sformatf("R9 pulse width v%0d", i), irq_o, 1'b0);
            chk($sformatf("R3 busy clear v%0d", i), ctl_rdata[0], 1'b0);
            chk($sformatf("R5/R6 rx data v%0d", i), rx_rdata, v.pat & msk);
            chk($sformatf("R6 tx order v%0d", i), cap, v.duplex ? (v.tx & msk) : 16'h0000);
            if (!v.duplex) chk($sformatf("R4 sd_o low v%0d", i), sd_hi, 0);
        end

        // R10 lock while busy
        clk_sel = 3'd2;
        cur_pat = 16'h0000; cur_wide = 1'b0; cur_lsb = 1'b0; dev_k = 0; cap_k = 0;
        wr_ctl(8'hC0);
        start_tx(16'h0055);
        repeat (5) cyc();
        wr_ctl(8'hBC);
        chk("R10 locked readback", ctl_rdata, 8'hC1);
        wait_irq(n);
        cyc();
        chk("R10 after idle", ctl_rdata, 8'hC0);

        // R11 disable mid-transfer
        clk_sel = 3'd3;
        start_tx(16'h00F0);
        repeat (10) cyc();
        base = irq_cnt;
        wr_ctl(8'h40);
        chk("R11 busy cleared", ctl_rdata, 8'h40);
        chk("R11 sck high", sck_o, 1'b1);
        repeat (300) cyc();
        chk("R11 no irq", irq_cnt - base, 0);
        start_tx(16'h00AA);
        chk("R11 start ignored when disabled", ctl_rdata[0], 1'b0);

        // R4 transmit write ignored in receive-only
        wr_ctl(8'h80);
        start_tx(16'h00AA);
        chk("R4 tx write no start", ctl_rdata[0], 1'b0);

        // R8 slave mode, late bit inert (R9)
        dev_on = 1'b0;
        clk_sel = 3'd7;
        wr_ctl(8'hC8);
        chk("R8 sck_oe low", sck_oe, 1'b0);
        chk("R8 sck_o high", sck_o, 1'b1);
        pat = 16'h003B;
        cap = '0;
        start_tx(16'h00A6);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            sck_i = 1'b0;
            sd_drv = pat[7-k];
            repeat (4) cyc();
            cap[7-k] = sd_o;
            sck_i = 1'b1;
            if (k < 7) repeat (4) cyc();
            else wait_irq(n);
        end
        chk("R8/R9 slave irq latency", n, 3);
        cyc();
        chk("R8 slave rx", rx_rdata, 16'h003B);
        chk("R8 slave tx", cap, 16'h00A6);

        // R12 repeat mode
        clk_sel = 3'd0;
        cur_pat = 16'h0000; cur_wide = 1'b0; cur_lsb = 1'b0;
        dev_k = 0; cap_k = 0; cap = '0; dev_on = 1'b1;
        wr_ctl(8'hC4);
        base = irq_cnt;
        start_tx(16'h0011);
        repeat (4) cyc();
        start_tx(16'h0022);
        wait_irq(n);
        chk("R12 busy held at first irq", ctl_rdata[0], 1'b1);
        cyc();
        cap_k = 0; cap = '0;
        wait_irq(n);
        cyc();
        chk("R12 second word", cap, 16'h0022);
        chk("R12 idle after second", ctl_rdata[0], 1'b0);
        chk("R12 irq count", irq_cnt - base, 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule